// File: doc/BRIEF.md
# Floating-Point Condition Predicate Evaluator

This block decides whether a 6-bit floating-point condition predicate holds for the condition flags of a status word. It reads three flags from that word: negative, zero and not-a-number. It returns a true/false result and flags any predicate code it cannot decode. When a test that does not handle unordered operands meets a NaN, it raises the branch-on-unordered exception bit. The exception byte of the status word is cleared and written back with that bit, and a trap request is raised if software has enabled trapping on unordered.

The result is meant to steer conditional branches, conditional byte stores, conditional traps and counted loops. For counted loops the block also computes the next loop-counter value and whether the loop branches back. All results are registered and appear one cycle after an input strobe.

Top module: `fp_cond_eval`

## Requirements
- R1: After reset deasserts, `valid_o`, `result_o`, `illegal_o`, `trap_o` and `loop_o` are 0, and `status_o` and `count_o` are all zero.
- R2: A predicate with bit 5 set is illegal. One cycle later `illegal_o`=1, `result_o`=0, `trap_o`=0 and `loop_o`=0, and `status_o` and `count_o` equal the inputs unchanged.
- R3: Status flags are N at bit 27, Z at bit 26 and NaN at bit 24. For relation codes 0..7 the result is: 0 false; 1 Z; 2 none of NaN, Z, N; 3 Z, or neither NaN nor N; 4 N with Z and NaN clear; 5 Z, or N with NaN clear; 6 neither NaN nor Z; 7 NaN clear.
- R4: A relation code c in 8..15 gives the inverse of the result for code c XOR 15.
- R5: Predicate bit 4 selects the unordered-unaware variant. The relation is taken from bits 3:0 only, so the result is the same as with bit 4 clear.
- R6: For a legal predicate, `status_o` is `status_i` with the exception byte (bits 15:8) cleared. Bit 15 may then be set under R7. All other bits are unchanged.
- R7: For a legal predicate, bit 15 of `status_o` (branch-on-unordered) is 1 exactly when predicate bit 4 is 1 and the NaN flag is 1.
- R8: `trap_o` is 1 exactly when a legal evaluation sets the branch-on-unordered bit and `trap_en_i` is 1.
- R9: `valid_o` pulses one cycle after each `valid_i`. Without `valid_i`, the registered results hold their values.
- R10: With `dec_i`=1, a legal predicate and a false result, `count_o` keeps bits 31:16 of `count_i` and holds bits 15:0 minus 1, modulo 2^16. `loop_o` is 1 unless bits 15:0 were zero. Otherwise `count_o`=`count_i` and `loop_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Evaluate strobe |
| pred_i | input | 6 | Condition predicate code |
| status_i | input | 32 | Current status word |
| trap_en_i | input | 1 | Trap enable for branch-on-unordered |
| dec_i | input | 1 | Counted-loop evaluation |
| count_i | input | 32 | Loop counter register value |
| valid_o | output | 1 | Results valid pulse |
| result_o | output | 1 | Predicate outcome |
| illegal_o | output | 1 | Predicate code is illegal |
| status_o | output | 32 | Updated status word |
| trap_o | output | 1 | Trap request for unordered |
| count_o | output | 32 | Next loop counter value |
| loop_o | output | 1 | Counted loop branches back |

## Verification
All 64 predicate codes are run against all eight combinations of N, Z and NaN. This separates each base relation from the others, each inverted code from its base, and the aware variant from the unaware one, which differ only in the unordered status bit. The status words also carry random exception and other bits, so clearing must touch only the exception byte. Trap enable is varied so the trap gating can be told apart from the status update. Counted-loop cases use low counter halves of 0, 1 and 0xFFFF under random upper halves, to show the wrap, the loop-exit condition and that the upper half is kept.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  parameter int STAT_W   = 32;
  parameter int N_BIT    = 27;
  parameter int Z_BIT    = 26;
  parameter int NAN_BIT  = 24;
  parameter int EXC_HI   = 15;
  parameter int EXC_LO   = 8;
  parameter int BSUN_BIT = 15;

  typedef enum logic [2:0] {
    REL_FALSE, REL_EQ, REL_GT, REL_GE, REL_LT, REL_LE, REL_GL, REL_ORD
  } rel_e;
endpackage

// File: rtl/fpc_pred_decode.sv
module fpc_pred_decode
  import fpc_pkg::*;
(
  input  logic [5:0] pred_i,
  output logic       illegal_o,
  output logic       unaware_o,
  output logic       invert_o,
  output rel_e       rel_o
);
  logic [3:0] code;

  always_comb begin
    illegal_o = pred_i[5];
    unaware_o = pred_i[4];
    invert_o  = pred_i[3];
    // upper half folds onto the complement relation
    code      = pred_i[3] ? (pred_i[3:0] ^ 4'hF) : pred_i[3:0];
    rel_o     = rel_e'(code[2:0]);
  end
endmodule

// File: rtl/fpc_relation.sv
module fpc_relation
  import fpc_pkg::*;
(
  input  rel_e rel_i,
  input  logic neg_i,
  input  logic zero_i,
  input  logic nan_i,
  output logic hit_o
);
  always_comb begin
    unique case (rel_i)
      REL_FALSE: hit_o = 1'b0;
      REL_EQ:    hit_o = zero_i;
      REL_GT:    hit_o = !nan_i && !zero_i && !neg_i;
      REL_GE:    hit_o = zero_i || (!nan_i && !neg_i);
      REL_LT:    hit_o = neg_i && !zero_i && !nan_i;
      REL_LE:    hit_o = zero_i || (neg_i && !nan_i);
      REL_GL:    hit_o = !nan_i && !zero_i;
      REL_ORD:   hit_o = !nan_i;
      default:   hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fpc_count_step.sv
module fpc_count_step #(
  parameter int CNT_W = 32,
  parameter int LO_W  = 16
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             dec_en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             loop_o
);
  logic [LO_W-1:0] lo, lo_dec;

  always_comb begin
    lo     = cnt_i[LO_W-1:0];
    lo_dec = lo - LO_W'(1);
    cnt_o  = dec_en_i ? {cnt_i[CNT_W-1:LO_W], lo_dec} : cnt_i;
    loop_o = dec_en_i && (lo != '0);
  end
endmodule

// File: rtl/fp_cond_eval.sv
module fp_cond_eval
  import fpc_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int LO_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [5:0]        pred_i,
  input  logic [STAT_W-1:0] status_i,
  input  logic              trap_en_i,
  input  logic              dec_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              valid_o,
  output logic              result_o,
  output logic              illegal_o,
  output logic [STAT_W-1:0] status_o,
  output logic              trap_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              loop_o
);
  localparam int EXC_W = EXC_HI - EXC_LO + 1;
  localparam logic [STAT_W-1:0] EXC_MASK =
    ({STAT_W{1'b1}} >> (STAT_W - EXC_W)) << EXC_LO;

  logic illegal, unaware, invert, hit, cond, bsun, loop_n;
  rel_e rel;
  logic [STAT_W-1:0] stat_n;
  logic [CNT_W-1:0]  cnt_n;

  fpc_pred_decode u_dec (
    .pred_i   (pred_i),
    .illegal_o(illegal),
    .unaware_o(unaware),
    .invert_o (invert),
    .rel_o    (rel)
  );

  fpc_relation u_rel (
    .rel_i (rel),
    .neg_i (status_i[N_BIT]),
    .zero_i(status_i[Z_BIT]),
    .nan_i (status_i[NAN_BIT]),
    .hit_o (hit)
  );

  always_comb begin
    cond = !illegal && (hit ^ invert);
    bsun = !illegal && unaware && status_i[NAN_BIT];
    if (illegal) begin
      stat_n = status_i;
    end else begin
      stat_n = status_i & ~EXC_MASK;
      stat_n[BSUN_BIT] = bsun;
    end
  end

  fpc_count_step #(.CNT_W(CNT_W), .LO_W(LO_W)) u_cnt (
    .cnt_i   (count_i),
    .dec_en_i(dec_i && !illegal && !cond),
    .cnt_o   (cnt_n),
    .loop_o  (loop_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      result_o  <= 1'b0;
      illegal_o <= 1'b0;
      status_o  <= '0;
      trap_o    <= 1'b0;
      count_o   <= '0;
      loop_o    <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o  <= cond;
        illegal_o <= illegal;
        status_o  <= stat_n;
        trap_o    <= bsun && trap_en_i;
        count_o   <= cnt_n;
        loop_o    <= loop_n;
      end
    end
  end
endmodule

// File: rtl/fp_cond_eval_chk.sv
module fp_cond_eval_chk
  import fpc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [5:0]        pred_i,
  input logic [STAT_W-1:0] status_i,
  input logic              trap_en_i,
  input logic              dec_i,
  input logic [CNT_W-1:0]  count_i,
  input logic              valid_o,
  input logic              result_o,
  input logic              illegal_o,
  input logic [STAT_W-1:0] status_o,
  input logic              trap_o,
  input logic [CNT_W-1:0]  count_o,
  input logic              loop_o
);
  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R9

  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(result_o) && $stable(status_o) && $stable(count_o))); // R9

  AST_ILLEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && pred_i[5]) |=> (illegal_o && !result_o && !trap_o && !loop_o
                                && status_o == $past(status_i))); // R2

  AST_EXC_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !pred_i[5]) |=> (status_o[EXC_HI-1:EXC_LO] == '0)); // R6

  AST_AWARE_NO_BSUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !pred_i[5] && !pred_i[4]) |=> !status_o[BSUN_BIT]); // R7

  AST_TRAP_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !pred_i[5]) |=> (trap_o == (status_o[BSUN_BIT] && $past(trap_en_i)))); // R8

  AST_NO_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !dec_i) |=> (!loop_o && count_o == $past(count_i))); // R10
endmodule

bind fp_cond_eval fp_cond_eval_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/fp_cond_eval_tb.sv
module fp_cond_eval_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        result;
    logic        illegal;
    logic [31:0] status;
    logic        trap;
    logic [31:0] count;
    logic        loop;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic valid_i = 1'b0, trap_en_i = 1'b0, dec_i = 1'b0;
  logic [5:0]  pred_i = '0;
  logic [31:0] status_i = '0, count_i = '0;
  logic valid_o, result_o, illegal_o, trap_o, loop_o;
  logic [31:0] status_o, count_o;

  int checks = 0, fails = 0;
  exp_t q[$];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_cond_eval u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .pred_i(pred_i),
    .status_i(status_i), .trap_en_i(trap_en_i), .dec_i(dec_i), .count_i(count_i),
    .valid_o(valid_o), .result_o(result_o), .illegal_o(illegal_o),
    .status_o(status_o), .trap_o(trap_o), .count_o(count_o), .loop_o(loop_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [5:0] p, input logic [31:0] st,
                                 input logic en, input logic dec, input logic [31:0] cnt);
    exp_t e;
    logic n, z, nan, r;
    logic [3:0] c;
    e = '0;
    if (p[5]) begin
      e.illegal = 1'b1; e.status = st; e.count = cnt;
      return e;
    end
    n = st[27]; z = st[26]; nan = st[24];
    c = p[3:0];
    if (c >= 4'd8) c = c ^ 4'hF;
    case (c[2:0])
      3'd0: r = 1'b0;
      3'd1: r = z;
      3'd2: r = !(nan || z || n);
      3'd3: r = z || !(nan || n);
      3'd4: r = n && !z && !nan;
      3'd5: r = z || (n && !nan);
      3'd6: r = !(nan || z);
      default: r = !nan;
    endcase
    if (p[3]) r = !r;
    e.result = r;
    e.status = st & 32'hFFFF_00FF;
    e.status[15] = p[4] && nan;
    e.trap = e.status[15] && en;
    if (dec && !r) begin
      e.count = {cnt[31:16], cnt[15:0] - 16'd1};
      e.loop  = (cnt[15:0] != 16'd0);
    end else begin
      e.count = cnt;
    end
    return e;
  endfunction

  task automatic drive(input logic [5:0] p, input logic [31:0] st, input logic en,
                       input logic dec, input logic [31:0] cnt);
    @(negedge clk);
    valid_i = 1'b1; pred_i = p; status_i = st; trap_en_i = en; dec_i = dec; count_i = cnt;
    q.push_back(model(p, st, en, dec, cnt));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0;
      pred_i = 6'($urandom); status_i = $urandom; count_i = $urandom; dec_i = 1'b1;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R9 actual=valid_o without strobe expected=none");
      end else begin
        exp_t e;
        e = q.pop_front();
        chk("R2 illegal", 32'(illegal_o), 32'(e.illegal));
        chk("R3 R4 R5 result", 32'(result_o), 32'(e.result));
        chk("R6 R7 status", status_o, e.status);
        chk("R8 trap", 32'(trap_o), 32'(e.trap));
        chk("R10 count", count_o, e.count);
        chk("R10 loop", 32'(loop_o), 32'(e.loop));
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] hold_s, hold_c;
    logic hold_r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 valid_o", 32'(valid_o), 0);
    chk("R1 result_o", 32'(result_o), 0);
    chk("R1 illegal_o", 32'(illegal_o), 0);
    chk("R1 trap_o", 32'(trap_o), 0);
    chk("R1 loop_o", 32'(loop_o), 0);
    chk("R1 status_o", status_o, 0);
    chk("R1 count_o", count_o, 0);

    // R3 R4 R5 R6 R7 R8 R2: every predicate against every flag combination
    for (int p = 0; p < 64; p++) begin
      for (int f = 0; f < 8; f++) begin
        logic [31:0] st;
        st = $urandom;
        st[27] = f[2]; st[26] = f[1]; st[24] = f[0];
        drive(6'(p), st, 1'($urandom), 1'($urandom), $urandom);
      end
    end
    idle(2);

    // R10 counted loop corners: false condition (code 0)
    drive(6'd0, 32'h0, 1'b0, 1'b1, 32'hABCD_0000);
    drive(6'd0, 32'h0, 1'b0, 1'b1, 32'h1234_0001);
    drive(6'd0, 32'h0, 1'b0, 1'b1, 32'h5A5A_FFFF);
    drive(6'd15, 32'h0, 1'b0, 1'b1, 32'h0000_0007); // true: no change
    drive(6'd32, 32'h0100_FF00, 1'b1, 1'b1, 32'h0000_0000); // R2 illegal: no decrement
    // R8 trap enable both ways on unaware NaN
    drive(6'd17, 32'h0100_0000, 1'b1, 1'b0, 32'h0);
    drive(6'd17, 32'h0100_0000, 1'b0, 1'b0, 32'h0);
    idle(2);

    // R9 hold: results keep values while no strobe
    drive(6'd17, 32'h0500_FF33, 1'b1, 1'b1, 32'h0000_0003);
    idle(1);
    hold_s = status_o; hold_c = count_o; hold_r = result_o;
    idle(4);
    chk("R9 hold status", status_o, hold_s);
    chk("R9 hold count", count_o, hold_c);
    chk("R9 hold result", 32'(result_o), 32'(hold_r));
    chk("R9 valid_o idle", 32'(valid_o), 0);
    chk("R9 all strobes answered", q.size(), 0);

    done = 1'b1;
    finish_run();
  end
endmodule